// File: doc/BRIEF.md
# Retriggerable one-shot pulse generator

This block is a fully synchronous stand-in for a resistor-capacitor timed monostable. Three asynchronous control pins feed it. `trigFallN` fires on a falling edge, `trigRise` fires on a rising edge, and `clearN` is an active-low clear that also fires on its own rising edge. A qualifying trigger starts a high pulse on `pulseOut`. The pulse lasts a number of clock cycles taken from `pulseLen`, and `pulseOutN` always carries the complement.

Each pin passes through a multi-flop synchroniser. Edges are then found by comparing each synchronised level with its value one cycle earlier. A small control module checks the gating rules between the three pins and sends load and clear strobes to a datapath module, which holds the down-counter. A trigger during a pulse reloads the counter, so the pulse stretches to a full length after the most recent trigger. Holding the clear low ends the pulse at once and blocks any new one.

Top module: `retrig_oneshot`

## Requirements
- R1: A falling edge on `trigFallN` starts a pulse only while `trigRise` is high and `clearN` is high.
- R2: A rising edge on `trigRise` starts a pulse only while `trigFallN` is low and `clearN` is high.
- R3: A rising edge on `clearN` starts a pulse only while `trigFallN` is low and `trigRise` is high.
- R4: While the synchronised `clearN` is low, `pulseOut` is 0 and `pulseOutN` is 1, and the pulse in progress is ended. Releasing the clear does not resume the pulse unless R3 applies.
- R5: A valid trigger during an active pulse restarts the timing, so `pulseOut` stays high until `pulseLen` cycles after the latest trigger's load.
- R6: With no trigger, `pulseOut` is 0 and `pulseOutN` is 1, and `pulseOutN` is always the inverse of `pulseOut`.
- R7: `pulseOut` stays high for exactly `pulseLen` cycles. The value is captured when the trigger is accepted, later changes do not affect the running pulse, and a value of 0 gives one cycle.
- R8: Suppose a pin change is set up before rising clock edge 1. Then `pulseOut` is first high after rising edge 3: two edges for the synchroniser and one edge to load the counter.
- R9: If `clearN` falls in the same cycle as a trigger edge on another pin, the clear wins and no pulse starts.
- R10: While the synchronous active-high `sysRst` is high, the counter is cleared, `pulseOut` is 0, and the synchronisers reset to the idle levels `trigFallN`=1, `trigRise`=0, `clearN`=1.
- R11: An edge in the non-triggering direction has no effect on `pulseOut`. This covers a rising `trigFallN` and a falling `trigRise`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sysRst | input | 1 | Synchronous active-high reset |
| trigFallN | input | 1 | Trigger pin, active on its falling edge (asynchronous) |
| trigRise | input | 1 | Trigger pin, active on its rising edge (asynchronous) |
| clearN | input | 1 | Active-low clear; its rising edge can also trigger (asynchronous) |
| pulseLen | input | LEN_W | Pulse length in clock cycles, 0 treated as 1 |
| pulseOut | output | 1 | Pulse output, high during the timed period |
| pulseOutN | output | 1 | Complement of pulseOut |

## Verification
The bench builds the block with `LEN_W` = 4 and keeps the default two-stage synchroniser. With this setting every pulse length from 0 to 15 can be swept and measured cycle by cycle, including the zero-to-one substitution. The narrow length also leaves room in the run to cover the full gating table: each of the three trigger pins against all four level combinations of the other two. Retrigger, clear during a pulse, a simultaneous clear and trigger, and reset during a pulse are each checked against a latency of three edges worked out in the bench.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Bit positions of the three control pins inside the synchronised vector
  localparam int PIN_FALL  = 0;
  localparam int PIN_RISE  = 1;
  localparam int PIN_CLEAR = 2;
  localparam int PIN_COUNT = 3;

  // Idle levels: falling-edge pin high, rising-edge pin low, clear released
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 3'b101;

  typedef struct packed {
    logic load;   // accept trigger: reload the duration counter
    logic clear;  // clear level active: kill the pulse
  } ctlStrobes_t;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             sysRst,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk) begin
    if (sysRst) begin
      stageQ <= {STAGES{RST_VAL}};
    end else begin
      for (int s = STAGES - 1; s > 0; s--) begin
        stageQ[s] <= stageQ[s-1];
      end
      stageQ[0] <= rawIn;
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic                 clk,
  input  logic                 sysRst,
  input  logic [PIN_COUNT-1:0] syncLvl,
  output ctlStrobes_t          strobes
);

  logic [PIN_COUNT-1:0] prevLvl;
  logic [PIN_COUNT-1:0] riseEdge;
  logic [PIN_COUNT-1:0] fallEdge;

  always_ff @(posedge clk) begin
    if (sysRst) prevLvl <= PIN_IDLE;
    else        prevLvl <= syncLvl;
  end

  generate
    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_edge
      assign riseEdge[p] = syncLvl[p] & ~prevLvl[p];
      assign fallEdge[p] = ~syncLvl[p] & prevLvl[p];
    end
  endgenerate

  logic fallLow, riseHigh, clrHigh;
  logic fireFall, fireRise, fireClear;

  always_comb begin
    fallLow   = ~syncLvl[PIN_FALL];
    riseHigh  = syncLvl[PIN_RISE];
    clrHigh   = syncLvl[PIN_CLEAR];
    fireFall  = fallEdge[PIN_FALL] & riseHigh;
    fireRise  = riseEdge[PIN_RISE] & fallLow;
    fireClear = riseEdge[PIN_CLEAR] & fallLow & riseHigh;
    // A low clear level masks every trigger path
    strobes.load  = clrHigh & (fireFall | fireRise | fireClear);
    strobes.clear = ~clrHigh;
  end

endmodule

// File: rtl/oneshot_dp.sv
module oneshot_dp
  import oneshot_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             sysRst,
  input  ctlStrobes_t      strobes,
  input  logic [LEN_W-1:0] pulseLen,
  output logic [LEN_W-1:0] cntVal,
  output logic             pulseOut,
  output logic             pulseOutN
);

  localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [LEN_W-1:0] loadVal;
  logic             cntLive;

  assign loadVal = (pulseLen == '0) ? LEN_ONE : pulseLen;
  assign cntLive = (cntVal != '0);

  always_ff @(posedge clk) begin
    if (sysRst)             cntVal <= '0;
    else if (strobes.clear) cntVal <= '0;
    else if (strobes.load)  cntVal <= loadVal;
    else if (cntLive)       cntVal <= cntVal - LEN_ONE;
  end

  assign pulseOut  = cntLive & ~strobes.clear;
  assign pulseOutN = ~pulseOut;

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             sysRst,
  input  logic             trigFallN,
  input  logic             trigRise,
  input  logic             clearN,
  input  logic [LEN_W-1:0] pulseLen,
  output logic             pulseOut,
  output logic             pulseOutN
);

  logic [PIN_COUNT-1:0] rawPins;
  logic [PIN_COUNT-1:0] syncLvl;
  ctlStrobes_t          strobes;
  logic [LEN_W-1:0]     cntVal;

  always_comb begin
    rawPins            = '0;
    rawPins[PIN_FALL]  = trigFallN;
    rawPins[PIN_RISE]  = trigRise;
    rawPins[PIN_CLEAR] = clearN;
  end

  oneshot_sync #(
    .WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk), .sysRst(sysRst), .rawIn(rawPins), .syncOut(syncLvl)
  );

  oneshot_ctrl u_ctrl (
    .clk(clk), .sysRst(sysRst), .syncLvl(syncLvl), .strobes(strobes)
  );

  oneshot_dp #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .sysRst(sysRst), .strobes(strobes), .pulseLen(pulseLen),
    .cntVal(cntVal), .pulseOut(pulseOut), .pulseOutN(pulseOutN)
  );

endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk
  import oneshot_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             sysRst,
  input logic [PIN_COUNT-1:0] syncLvl,
  input ctlStrobes_t      strobes,
  input logic [LEN_W-1:0] cntVal,
  input logic             pulseOut,
  input logic             pulseOutN
);

  // R4: low synchronised clear keeps the output low
  assert_clear_forces_low_R4: assert property (@(posedge clk) disable iff (sysRst)
    !syncLvl[PIN_CLEAR] |-> (!pulseOut && pulseOutN));

  // R9: a clear cycle leaves the counter empty, no load sneaks through
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (sysRst)
    !syncLvl[PIN_CLEAR] |=> (cntVal == '0));

  // R5: an accepted trigger makes the output high next cycle unless cleared
  assert_load_raises_R5: assert property (@(posedge clk) disable iff (sysRst)
    strobes.load |=> (pulseOut || !syncLvl[PIN_CLEAR]));

  // R6: output only rises after an accepted trigger
  assert_no_spurious_rise_R6: assert property (@(posedge clk) disable iff (sysRst)
    $rose(pulseOut) |-> $past(strobes.load));

  // R7: without load or clear the counter counts down by one
  assert_count_down_R7: assert property (@(posedge clk) disable iff (sysRst)
    (!strobes.load && syncLvl[PIN_CLEAR] && cntVal != '0) |=> (cntVal == $past(cntVal) - 1'b1));

  // R10: reset empties the counter
  assert_reset_clears_R10: assert property (@(posedge clk)
    sysRst |=> (cntVal == '0));

  // R6: complementary outputs
  always_comb begin
    if (!sysRst) assert_complement_R6: assert (pulseOutN == !pulseOut);
  end

endmodule

bind retrig_oneshot oneshot_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .sysRst(sysRst), .syncLvl(syncLvl), .strobes(strobes),
  .cntVal(cntVal), .pulseOut(pulseOut), .pulseOutN(pulseOutN)
);

// File: tb/sim_retrig_oneshot.sv
`timescale 1ns/1ps
module sim_retrig_oneshot;

  localparam int LW = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic sysRst = 1'b1;
  logic trigFallN = 1'b1;
  logic trigRise = 1'b0;
  logic clearN = 1'b1;
  logic [LW-1:0] pulseLen = LW'(5);
  logic pulseOut, pulseOutN;

  int testCount = 0;
  int failCount = 0;
  int idx, firstHigh, lastHigh, highCnt;
  bit compOk;

  always #4 clk = ~clk;

  retrig_oneshot #(.LEN_W(LW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .sysRst(sysRst), .trigFallN(trigFallN), .trigRise(trigRise),
    .clearN(clearN), .pulseLen(pulseLen), .pulseOut(pulseOut), .pulseOutN(pulseOutN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startWatch();
    idx = 0; firstHigh = -1; lastHigh = -1; highCnt = 0; compOk = 1'b1;
  endtask

  task automatic watch(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      idx++;
      if (pulseOutN !== ~pulseOut) compOk = 1'b0;
      if (pulseOut === 1'b1) begin
        highCnt++;
        if (firstHigh < 0) firstHigh = idx;
        lastHigh = idx;
      end
    end
  endtask

  task automatic expectPulse(input string tag, input int expLen);
    check(highCnt == expLen, {tag, " high cycles"}, highCnt, expLen);
    if (expLen > 0) begin
      check(firstHigh == LAT, {tag, " first high (R8)"}, firstHigh, LAT);
      check(lastHigh == LAT + expLen - 1, {tag, " last high"}, lastHigh, LAT + expLen - 1);
    end
    check(compOk, "R6 complement during trial", compOk, 1);
  endtask

  task automatic setPins(input logic a, input logic b, input logic c);
    trigFallN = a; trigRise = b; clearN = c;
  endtask

  initial begin
    #(8 * 150000);
    failCount++;
    $display("FAIL watchdog expired, run hung actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    // R10 / R6: reset state
    idle(3);
    check(pulseOut == 1'b0, "R10 reset pulseOut", pulseOut, 0);
    check(pulseOutN == 1'b1, "R6 reset pulseOutN", pulseOutN, 1);
    sysRst = 1'b0;
    idle(10);
    check(pulseOut == 1'b0, "R6 idle pulseOut", pulseOut, 0);

    // R1: falling edge on trigFallN against every level of the others
    for (int m = 0; m < 4; m++) begin
      logic bl = m[0], cl = m[1];
      pulseLen = LW'(5);
      setPins(1'b1, bl, cl); idle(30);
      startWatch(); trigFallN = 1'b0; watch(20);
      expectPulse($sformatf("R1 fall b=%0d c=%0d", bl, cl), (bl && cl) ? 5 : 0);
    end

    // R2: rising edge on trigRise
    for (int m = 0; m < 4; m++) begin
      logic al = m[0], cl = m[1];
      setPins(al, 1'b0, cl); idle(30);
      startWatch(); trigRise = 1'b1; watch(20);
      expectPulse($sformatf("R2 rise a=%0d c=%0d", al, cl), (!al && cl) ? 5 : 0);
    end

    // R3: rising edge on clearN
    for (int m = 0; m < 4; m++) begin
      logic al = m[0], bl = m[1];
      setPins(al, bl, 1'b0); idle(30);
      startWatch(); clearN = 1'b1; watch(20);
      expectPulse($sformatf("R3 clear rise a=%0d b=%0d", al, bl), (!al && bl) ? 5 : 0);
    end

    // R11: edges in the non-triggering direction
    setPins(1'b0, 1'b1, 1'b1); idle(30);
    startWatch(); trigFallN = 1'b1; watch(20);
    expectPulse("R11 rising trigFallN", 0);
    setPins(1'b0, 1'b1, 1'b1); idle(30);
    startWatch(); trigRise = 1'b0; watch(20);
    expectPulse("R11 falling trigRise", 0);

    // R7: every length, value changed after capture
    for (int L = 0; L < 16; L++) begin
      pulseLen = LW'(L);
      setPins(1'b1, 1'b1, 1'b1); idle(30);
      startWatch(); trigFallN = 1'b0; watch(4);
      pulseLen = LW'(L) ^ LW'(4'hA);
      watch(20);
      expectPulse($sformatf("R7 length %0d", L), (L == 0) ? 1 : L);
    end

    // R5: retrigger extends the pulse
    pulseLen = LW'(6);
    setPins(1'b0, 1'b0, 1'b1); idle(30);
    startWatch(); trigRise = 1'b1; watch(3);
    trigRise = 1'b0; watch(2);
    trigRise = 1'b1; watch(25);
    expectPulse("R5 retrigger", 11);

    // R4: clear during pulse, release does not resume
    pulseLen = LW'(10);
    setPins(1'b1, 1'b1, 1'b1); idle(30);
    startWatch(); trigFallN = 1'b0; watch(2);
    trigFallN = 1'b1; watch(3);
    clearN = 1'b0; watch(5);
    clearN = 1'b1; watch(25);
    expectPulse("R4 clear cuts pulse", 4);

    // R9: clear and trigger in the same cycle
    pulseLen = LW'(5);
    setPins(1'b1, 1'b1, 1'b1); idle(30);
    startWatch(); trigFallN = 1'b0; clearN = 1'b0; watch(20);
    expectPulse("R9 clear beats trigger", 0);
    setPins(1'b1, 1'b1, 1'b1); idle(30);

    // R10: reset during a pulse
    pulseLen = LW'(10);
    setPins(1'b1, 1'b1, 1'b1); idle(30);
    startWatch(); trigFallN = 1'b0; watch(2);
    trigFallN = 1'b1; watch(3);
    sysRst = 1'b1; watch(2);
    sysRst = 1'b0; watch(20);
    expectPulse("R10 reset cuts pulse", 3);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule